// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of a parallel NOR-style flash. After the host has issued a program or erase command sequence elsewhere, it pulses `start_i` with the target address, the expected byte, the kind of operation and a detection method. The poller then reads that address again and again over a simple request/response read port until the flash reports that the internal write has finished.

Two detection methods are offered. The toggle method watches a status bit that flips on every read while the flash is busy. The data-polling method watches the top data bit, which reads inverted while a program runs and reads 0 while an erase runs. The flash finishes asynchronously to the reads, so a single good-looking read can be misleading. The poller therefore accepts completion only after two further reads both pass the same test. It then waits a settle interval and compares one final full-byte read against the expected value. Each operation kind has its own cycle budget. A run that exceeds the budget ends in failure.

Top module: `flash_wait_poller`

## Requirements
- R1: `start_i` is acted on only while the poller is idle. A start during a run changes neither `rd_addr_o` nor `elapsed_o`.
- R2: Each read is a single-cycle `rd_req_o` pulse with `rd_addr_o` equal to the address latched at start. At most one read is outstanding, and the next request is issued only after `rd_valid_i` has answered the previous one.
- R3: With `mode_i` = 0 (toggle), a completion candidate occurs when bit 6 of the newest read equals bit 6 of the read before it. While bit 6 keeps changing, polling continues.
- R4: With `mode_i` = 1 (data polling), a completion candidate occurs when bit 7 of a read equals bit 7 of the effective expected byte. The effective expected byte is `expect_i` for a program (`erase_i` = 0) and 8'hFF for an erase (`erase_i` = 1), in which case `expect_i` is ignored.
- R5: After a candidate, two more reads are made, and each must pass the same test as in R3 or R4. If either one fails, polling resumes and no result is reported.
- R6: After both confirming reads pass, the poller waits SETTLE_CYC cycles and then makes one final read. It pulses `done_o` if all 8 bits equal the effective expected byte, and pulses `fail_o` otherwise.
- R7: If no result is reached, `fail_o` rises exactly PROG_TMO (program) or ERASE_TMO (erase) clock cycles after the edge that accepted the start.
- R8: `done_o` and `fail_o` are single-cycle pulses that are never high together. The poller is idle again in the following cycle.
- R9: `elapsed_o` counts clock cycles since the accepted start. A new start clears it, and it holds its value once a result has been given.
- R10: After reset, `rd_req_o`, `done_o` and `fail_o` are 0, `elapsed_o` is 0, and the poller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin waiting for a write (idle only) |
| mode_i | input | 1 | 0 = toggle method, 1 = data polling |
| erase_i | input | 1 | 1 = erase (expected 8'hFF, erase budget), 0 = program |
| addr_i | input | ADDR_W | Location to poll |
| expect_i | input | 8 | Byte the program should leave |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read response strobe |
| rd_data_i | input | 8 | Read response byte |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Timeout or final-mismatch pulse |
| elapsed_o | output | clog2(max budget + 1) | Cycles since accepted start |

## Verification
A corrupted phase register shows up at the read port within one response. Examples are skipped confirmations, which give fewer reads before `done_o`, and extra or missing requests. The bench therefore counts the requests per run against hand-traced scripts. A stuck or miscounted budget counter moves the `fail_o` edge or the held `elapsed_o` value, and both are compared to the exact cycle. A latch that wrongly accepts a restart shows on the very next cycle as a changed address or a cleared cycle count.

// File: rtl/fpoll_pkg.sv
// Shared types for the flash completion poller.
// Assumes byte-wide flash status with the toggle flag in bit 6 and the
// inverted-data flag in bit 7.
package fpoll_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_READ1, ST_READ2, ST_COMPARE,
        ST_CONFIRM1, ST_CONFIRM2, ST_SETTLE, ST_DONE, ST_FAIL
    } fpoll_state_e;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_POLL   = 1'b1
    } fpoll_mode_e;
endpackage

// File: rtl/fpoll_timer.sv
// Per-run cycle counter with an operation-dependent budget.
// Assumes clear_i and run_i are never high in the same cycle.
module fpoll_timer #(
    parameter int unsigned PROG_TMO  = 5000,
    parameter int unsigned ERASE_TMO = 25000000,
    parameter int unsigned W         = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic         erase_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    localparam logic [W-1:0] PROG_LAST  = W'(PROG_TMO - 1);
    localparam logic [W-1:0] ERASE_LAST = W'(ERASE_TMO - 1);
    localparam logic [W-1:0] PROG_LIM   = W'(PROG_TMO);
    localparam logic [W-1:0] ERASE_LIM  = W'(ERASE_TMO);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last_val;

    // Select the final in-budget count for this operation kind.
    always_comb last_val = erase_i ? ERASE_LAST : PROG_LAST;

    // Count active cycles; restart on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (run_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign count_o  = cnt_q;
    assign expire_o = run_i && (cnt_q == last_val);

    // R7: a running count never reaches the budget
    p_below_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < (erase_i ? ERASE_LIM : PROG_LIM)));
    // R9: count frozen when neither running nor cleared
    p_count_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fpoll_settle.sv
// Down-counter that holds off the final read for SETTLE_CYC cycles.
// Assumes load_i is a single-cycle pulse.
module fpoll_settle #(
    parameter int unsigned SETTLE_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    localparam int unsigned SW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

    logic [SW-1:0] cnt_q;

    // Load the delay, then run down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= SW'(SETTLE_CYC);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R6: a load always leaves the full delay ahead
    p_settle_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == SW'(SETTLE_CYC)));
endmodule

// File: rtl/fpoll_judge.sv
// Decides whether one status sample looks like a finished write.
// Toggle: flag equals the previous sample's flag. Polling: data bit
// equals the expected bit. Purely combinational.
module fpoll_judge
    import fpoll_pkg::*;
(
    input  fpoll_mode_e mode_i,
    input  logic        samp_tgl_i,
    input  logic        samp_poll_i,
    input  logic        prev_tgl_i,
    input  logic        want_poll_i,
    output logic        ok_o
);
    // Apply the test of the selected method.
    always_comb begin
        if (mode_i == MODE_TOGGLE) ok_o = (samp_tgl_i == prev_tgl_i);
        else                       ok_o = (samp_poll_i == want_poll_i);
    end
endmodule

// File: rtl/flash_wait_poller.sv
// Host-side poller that waits for a flash program/erase to finish.
// Reads the target repeatedly, detects completion by toggle or data
// polling, demands two confirming reads, settles, then checks the full
// byte. Assumes a read response arrives no earlier than one cycle after
// its request and that the command sequence was sent beforehand.
module flash_wait_poller
    import fpoll_pkg::*;
#(
    parameter int unsigned ADDR_W     = 19,
    parameter int unsigned PROG_TMO   = 5000,
    parameter int unsigned ERASE_TMO  = 25000000,
    parameter int unsigned SETTLE_CYC = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        expect_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [7:0]        rd_data_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [$clog2(((PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO) + 1)-1:0] elapsed_o
);
    localparam int unsigned TMO_MAX = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
    localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);

    fpoll_state_e      state_q;
    fpoll_mode_e       mode_q;
    logic              erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        exp_q;
    logic              req_q;
    logic              pend_q;
    logic              last_tgl_q;
    logic [1:0]        cur_q;      // {bit7, bit6} of the sample under test

    logic              got;
    logic              want_read;
    logic              judge_ok;
    logic              tmo_hit;
    logic              settle_zero;
    logic              settle_load;
    logic              run;
    logic              accept;
    logic              samp_tgl;
    logic              samp_poll;
    fpoll_state_e      retry_st;
    logic [TMO_W-1:0]  elapsed;

    // Decode per-cycle control from the phase register.
    always_comb begin
        accept    = (state_q == ST_IDLE) && start_i;
        run       = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
        got       = pend_q && rd_valid_i;
        want_read = (state_q inside {ST_READ1, ST_READ2, ST_CONFIRM1, ST_CONFIRM2})
                    || ((state_q == ST_SETTLE) && settle_zero);
        samp_tgl  = (state_q == ST_COMPARE) ? cur_q[0] : rd_data_i[6];
        samp_poll = (state_q == ST_COMPARE) ? cur_q[1] : rd_data_i[7];
        retry_st  = (mode_q == MODE_TOGGLE) ? ST_READ2 : ST_READ1;
        settle_load = got && (state_q == ST_CONFIRM2) && judge_ok && !tmo_hit;
    end

    fpoll_judge u_judge (
        .mode_i      (mode_q),
        .samp_tgl_i  (samp_tgl),
        .samp_poll_i (samp_poll),
        .prev_tgl_i  (last_tgl_q),
        .want_poll_i (exp_q[7]),
        .ok_o        (judge_ok)
    );

    fpoll_timer #(.PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO), .W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (run),
        .erase_i  (erase_q),
        .count_o  (elapsed),
        .expire_o (tmo_hit)
    );

    fpoll_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (settle_load),
        .zero_o (settle_zero)
    );

    // Phase sequencing, read issue and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_TOGGLE;
            erase_q    <= 1'b0;
            addr_q     <= '0;
            exp_q      <= '0;
            req_q      <= 1'b0;
            pend_q     <= 1'b0;
            last_tgl_q <= 1'b0;
            cur_q      <= '0;
        end else begin
            req_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q  <= addr_i;
                        mode_q  <= fpoll_mode_e'(mode_i);
                        erase_q <= erase_i;
                        exp_q   <= erase_i ? 8'hFF : expect_i;
                        pend_q  <= 1'b0;
                        state_q <= ST_READ1;
                    end
                end
                ST_DONE, ST_FAIL: state_q <= ST_IDLE;
                default: begin
                    if (tmo_hit) begin
                        pend_q  <= 1'b0;
                        state_q <= ST_FAIL;
                    end else begin
                        if (want_read && !pend_q) begin
                            req_q  <= 1'b1;
                            pend_q <= 1'b1;
                        end
                        if (got) pend_q <= 1'b0;
                        if (state_q == ST_COMPARE) begin
                            last_tgl_q <= cur_q[0];
                            state_q    <= judge_ok ? ST_CONFIRM1 : retry_st;
                        end else if (got) begin
                            case (state_q)
                                ST_READ1: begin
                                    if (mode_q == MODE_TOGGLE) begin
                                        last_tgl_q <= rd_data_i[6];
                                        state_q    <= ST_READ2;
                                    end else begin
                                        cur_q   <= rd_data_i[7:6];
                                        state_q <= ST_COMPARE;
                                    end
                                end
                                ST_READ2: begin
                                    cur_q   <= rd_data_i[7:6];
                                    state_q <= ST_COMPARE;
                                end
                                ST_CONFIRM1: begin
                                    last_tgl_q <= rd_data_i[6];
                                    state_q    <= judge_ok ? ST_CONFIRM2 : retry_st;
                                end
                                ST_CONFIRM2: begin
                                    last_tgl_q <= rd_data_i[6];
                                    state_q    <= judge_ok ? ST_SETTLE : retry_st;
                                end
                                ST_SETTLE: state_q <= (rd_data_i == exp_q) ? ST_DONE : ST_FAIL;
                                default: ;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign rd_req_o  = req_q;
    assign rd_addr_o = addr_q;
    assign done_o    = (state_q == ST_DONE);
    assign fail_o    = (state_q == ST_FAIL);
    assign elapsed_o = elapsed;

    // R8: never both outcomes at once
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    // R8: outcomes are single-cycle pulses
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_fail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);
    // R2: a request lasts exactly one cycle
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    // R1: address cannot change during a run
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(rd_addr_o));
    // R6: success only straight out of the settle phase
    p_done_from_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_q) == ST_SETTLE));
    // R5: settle is entered only after the second confirmation
    p_settle_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SETTLE) && ($past(state_q) != ST_SETTLE))
            |-> ($past(state_q) == ST_CONFIRM2));
endmodule

// File: tb/test_flash_wait_poller.sv
`timescale 1ns/1ps
module test_flash_wait_poller;
    localparam int unsigned ADDR_W = 19;
    localparam int unsigned PTMO   = 300;
    localparam int unsigned ETMO   = 600;
    localparam int unsigned SETTLE = 5;
    localparam int unsigned TW     = $clog2(ETMO + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              mode_i = 1'b0;
    logic              erase_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [7:0]        expect_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_valid_i = 1'b0;
    logic [7:0]        rd_data_i = '0;
    logic              done_o;
    logic              fail_o;
    logic [TW-1:0]     elapsed_o;

    int n_chk = 0;
    int n_bad = 0;

    // read model state
    logic [7:0]        script [8];
    int                script_len = 1;
    int                idx = 0;
    int                nreads = 0;
    int                addr_bad = 0;
    logic              resp_en = 1'b1;
    logic              model_clr = 1'b0;
    logic [ADDR_W-1:0] want_addr = '0;

    always #2 clk = ~clk;

    flash_wait_poller #(.ADDR_W(ADDR_W), .PROG_TMO(PTMO), .ERASE_TMO(ETMO),
                        .SETTLE_CYC(SETTLE)) i_flash_wait_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .erase_i(erase_i), .addr_i(addr_i), .expect_i(expect_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .done_o(done_o), .fail_o(fail_o),
        .elapsed_o(elapsed_o));

    // Scripted flash: answers each request one cycle later.
    always @(posedge clk) begin
        rd_valid_i <= 1'b0;
        if (model_clr) begin
            idx <= 0; nreads <= 0; addr_bad <= 0;
        end else if (rd_req_o) begin
            nreads <= nreads + 1;
            if (rd_addr_o != want_addr) addr_bad <= addr_bad + 1;
            if (resp_en) begin
                rd_valid_i <= 1'b1;
                rd_data_i  <= script[idx];
                if (idx < script_len - 1) idx <= idx + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
    endtask

    // Start one run; result 1 = done, 2 = fail, 0 = none; cyc = edges after start.
    task automatic run_op(input logic m, input logic e, input logic [ADDR_W-1:0] a,
                          input logic [7:0] x, output int res, output int cyc);
        clear_model();
        want_addr = a;
        start_i = 1'b1; mode_i = m; erase_i = e; addr_i = a; expect_i = x;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && !fail_o && cyc < 3000) begin
            @(negedge clk); cyc++;
        end
        res = done_o ? 1 : (fail_o ? 2 : 0);
    endtask

    task automatic t_reset();
        chk("R10", "rd_req", int'(rd_req_o), 0);
        chk("R10", "done", int'(done_o), 0);
        chk("R10", "fail", int'(fail_o), 0);
        chk("R10", "elapsed", int'(elapsed_o), 0);
    endtask

    task automatic t_toggle_program();
        int res, cyc;
        script = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h1A, 8'h1A, 8'h1A, 8'h1A};
        script_len = 6; resp_en = 1'b1;
        run_op(1'b0, 1'b0, 19'h12345, 8'h1A, res, cyc);
        chk("R3", "toggle program outcome", res, 1);
        chk("R3", "toggle program reads", nreads, 9);
        chk("R2", "read address", addr_bad, 0);
        @(negedge clk);
        chk("R8", "done one cycle", int'(done_o), 0);
    endtask

    task automatic t_toggle_race();
        int res, cyc;
        script = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        script_len = 4; resp_en = 1'b1;
        run_op(1'b0, 1'b0, 19'h00100, 8'h00, res, cyc);
        chk("R5", "toggle race outcome", res, 1);
        chk("R5", "toggle race reads", nreads, 8);
    endtask

    task automatic t_poll_program();
        int res, cyc;
        script = '{8'h80, 8'h80, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C};
        script_len = 3; resp_en = 1'b1;
        run_op(1'b1, 1'b0, 19'h7FFFF, 8'h3C, res, cyc);
        chk("R4", "poll program outcome", res, 1);
        chk("R4", "poll program reads", nreads, 6);
        chk("R2", "read address", addr_bad, 0);
    endtask

    task automatic t_poll_race_first();
        int res, cyc;
        script = '{8'h80, 8'h3C, 8'h80, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C};
        script_len = 4; resp_en = 1'b1;
        run_op(1'b1, 1'b0, 19'h00042, 8'h3C, res, cyc);
        chk("R5", "race at first confirm outcome", res, 1);
        chk("R5", "race at first confirm reads", nreads, 7);
    endtask

    task automatic t_poll_race_second();
        int res, cyc;
        script = '{8'h3C, 8'h3C, 8'h80, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C};
        script_len = 4; resp_en = 1'b1;
        run_op(1'b1, 1'b0, 19'h00043, 8'h3C, res, cyc);
        chk("R5", "race at second confirm outcome", res, 1);
        chk("R5", "race at second confirm reads", nreads, 7);
    endtask

    task automatic t_poll_erase();
        int res, cyc;
        script = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        script_len = 3; resp_en = 1'b1;
        run_op(1'b1, 1'b1, 19'h01000, 8'h00, res, cyc);
        chk("R4", "erase poll outcome (expect_i ignored)", res, 1);
        chk("R4", "erase poll reads", nreads, 6);
    endtask

    task automatic t_final_mismatch();
        int res, cyc;
        script = '{8'h3C, 8'h3C, 8'h3C, 8'h3D, 8'h3D, 8'h3D, 8'h3D, 8'h3D};
        script_len = 4; resp_en = 1'b1;
        run_op(1'b1, 1'b0, 19'h00077, 8'h3C, res, cyc);
        chk("R6", "final byte mismatch outcome", res, 2);
        chk("R6", "final byte mismatch reads", nreads, 4);
    endtask

    task automatic t_prog_timeout();
        int res, cyc;
        resp_en = 1'b0;
        run_op(1'b1, 1'b0, 19'h00500, 8'h3C, res, cyc);
        chk("R7", "program timeout outcome", res, 2);
        chk("R7", "program timeout cycle", cyc, PTMO);
        chk("R2", "single outstanding read", nreads, 1);
        chk("R9", "elapsed at fail", int'(elapsed_o), PTMO);
        repeat (5) @(negedge clk);
        chk("R9", "elapsed held", int'(elapsed_o), PTMO);
        resp_en = 1'b1;
    endtask

    task automatic t_erase_timeout();
        int res, cyc;
        resp_en = 1'b0;
        run_op(1'b0, 1'b1, 19'h00600, 8'h00, res, cyc);
        chk("R7", "erase timeout outcome", res, 2);
        chk("R7", "erase timeout cycle", cyc, ETMO);
        resp_en = 1'b1;
    endtask

    task automatic t_start_ignored();
        int cyc;
        clear_model();
        resp_en = 1'b0;
        want_addr = 19'h00AAA;
        start_i = 1'b1; mode_i = 1'b1; erase_i = 1'b0; addr_i = 19'h00AAA; expect_i = 8'h11;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9", "elapsed mid-run", int'(elapsed_o), 20);
        start_i = 1'b1; addr_i = 19'h00555; erase_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1", "address after busy start", int'(rd_addr_o), 'hAAA);
        chk("R1", "elapsed after busy start", int'(elapsed_o), 21);
        cyc = 21;
        while (!fail_o && cyc < 3000) begin
            @(negedge clk); cyc++;
        end
        chk("R1", "original budget kept", cyc, PTMO);
        resp_en = 1'b1;
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_toggle_program();
        t_toggle_race();
        t_poll_program();
        t_poll_race_first();
        t_poll_race_second();
        t_poll_erase();
        t_final_mismatch();
        t_prog_timeout();
        t_erase_timeout();
        t_start_ignored();
        repeat (3) @(negedge clk);
        report();
    end
endmodule